// File: doc/BRIEF.md
# Serial Link Hot-Plug Controller

This block supervises a serial storage link for the arrival and departure of a device. It starts by asking the device for a link reset. While no device has answered, it keeps asking on a fixed long period. Once the device has sent its init answer and the physical layer reports ready, the link is declared ready. From then on, a short loss timer watches for line activity. If the line stays silent for too long, the block drops back into reset polling and starts asking again.

Every transition of the link-ready status, whether on plug-in or on removal, sets a sticky change flag. Software clears this flag by writing a one to it. A maskable interrupt is the flag gated by an enable bit. The physical-layer inputs are simplified to three single-bit indications. Both timers are derived from the clock frequency parameter.

Top module: `hotplug_ctrl`

## Requirements
- R1: In the first cycle after synchronous reset is released, `comResetReq` is 1, `linkReady` is 0, `irq` is 0 and both registers read 0.
- R2: Every reset request on `comResetReq` is a single-cycle pulse.
- R3: In the polling state, until an init answer arrives, `comResetReq` pulses once every POLL_NS worth of clock cycles. With 125 MHz and 800 ns this is every 100 cycles. The period counts from the cycle the polling state is entered.
- R4: A cycle with `rxInit` high in the polling state stops further reset pulses. The link becomes ready (`linkReady`=1) at the first clock edge where `phyRdy` is high and an init has been seen, including in that same cycle.
- R5: In the ready state, LOSS_NS worth of consecutive cycles without `sigValid` return the block to polling. With 125 MHz and 200 ns this is 25 cycles. A reset pulse is issued in the first polling cycle.
- R6: Any ready-state cycle with `sigValid` high restarts the loss timer.
- R7: Every change of `linkReady` sets the change flag, which reads as bit 16 of the status register at `regAddr`=0. It is set at the same edge that changes `linkReady`.
- R8: The change flag is sticky. It is cleared only by a write to address 0 with bit 16 set. Writes with bit 16 clear leave it unchanged. A new change in the same cycle as a clear wins.
- R9: Bit 16 at `regAddr`=1 is a read/write enable. `irq` is 1 exactly when the flag and the enable are both 1.
- R10: Asserting reset in any state returns the block to its power-up condition, so a new first reset request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sigValid | input | 1 | Valid line activity seen this cycle |
| rxInit | input | 1 | Init answer received from the device |
| phyRdy | input | 1 | Physical layer reports ready |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 status, 1 enable |
| regWrData | input | 32 | Register write data |
| comResetReq | output | 1 | Single-cycle reset request to the device |
| linkReady | output | 1 | Link is in the ready state |
| irq | output | 1 | Change interrupt (flag AND enable) |
| regRdData | output | 32 | Combinational read data for `regAddr` |

## Verification
`linkReady`, the change flag and `irq` all move at the very clock edge that sees the deciding input. `comResetReq` is decoded from registered state, so it is already valid before the first edge after reset release, and after any edge where the state changes. Register reads are combinational and register writes take effect at the next edge. The bench therefore drives every input just after a rising edge, counts the edges exactly (for example 100 to the next poll pulse and 25 silent edges to the loss fall-back), and samples one time unit after the edge that should have produced the result.

// File: rtl/hotplug_pkg.sv
package hotplug_pkg;

  typedef enum logic {ST_POLL = 1'b0, ST_READY = 1'b1} link_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pollClr;
    logic lossClr;
    logic setChg;
  } dp_strobe_t;

  // counter status back to control
  typedef struct packed {
    logic pollAtZero;
    logic lossAtLast;
  } dp_status_t;

  localparam int REG_W   = 32;
  localparam int CHG_BIT = 16;

  function automatic longint unsigned nsToCycles(longint unsigned hz, longint unsigned ns);
    longint unsigned cyc;
    cyc = (hz * ns) / 64'd1_000_000_000;
    return (cyc < 64'd2) ? 64'd2 : cyc;
  endfunction

endpackage

// File: rtl/hotplug_ctrl_fsm.sv
module hotplug_ctrl_fsm
  import hotplug_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sigValid,
  input  logic       rxInit,
  input  logic       phyRdy,
  input  dp_status_t dpStat,
  output dp_strobe_t dpStrb,
  output logic       comResetReq,
  output logic       linkReady
);

  link_state_e state, nextState;
  logic initSeen;
  logic lossFire;

  assign lossFire = (state == ST_READY) && !sigValid && dpStat.lossAtLast;

  always_comb begin
    nextState = state;
    case (state)
      ST_POLL:  if ((initSeen || rxInit) && phyRdy) nextState = ST_READY;
      ST_READY: if (lossFire) nextState = ST_POLL;
      default:  nextState = ST_POLL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_POLL;
      initSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (lossFire)
        initSeen <= 1'b0;
      else if (state == ST_POLL && rxInit)
        initSeen <= 1'b1;
    end
  end

  always_comb begin
    dpStrb.pollClr = (state == ST_READY);
    dpStrb.lossClr = (state != ST_READY) || sigValid;
    dpStrb.setChg  = (nextState != state);
  end

  assign linkReady   = (state == ST_READY);
  assign comResetReq = (state == ST_POLL) && !initSeen && dpStat.pollAtZero;

  // R2: a request never lasts two cycles
  p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
    comResetReq |=> !comResetReq);

  // R4: ready is entered only with phy ready and an init seen
  p_enter_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (linkReady && !$past(linkReady)) |-> ($past(phyRdy) && ($past(initSeen) || $past(rxInit))));

  // R5: loss expiry leaves ready and re-issues a request
  p_loss_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (linkReady && !sigValid && dpStat.lossAtLast) |=> (!linkReady && comResetReq));

endmodule

// File: rtl/hotplug_ctrl_dp.sv
module hotplug_ctrl_dp
  import hotplug_pkg::*;
#(
  parameter longint unsigned POLL_CYC = 64'd12_500_000,
  parameter longint unsigned LOSS_CYC = 64'd25
) (
  input  logic             clk,
  input  logic             rst,
  input  dp_strobe_t       dpStrb,
  output dp_status_t       dpStat,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irq
);

  localparam int POLL_W = $clog2(POLL_CYC);
  localparam int LOSS_W = $clog2(LOSS_CYC);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_CYC - 64'd1);
  localparam logic [LOSS_W-1:0] LOSS_LAST = LOSS_W'(LOSS_CYC - 64'd1);

  logic [POLL_W-1:0] pollCnt;
  logic [LOSS_W-1:0] lossCnt;
  logic chgFlag, chgEn;
  logic clrHit, enWr;
  logic unusedWrBits;

  always_ff @(posedge clk) begin
    if (rst || dpStrb.pollClr)
      pollCnt <= '0;
    else if (pollCnt == POLL_LAST)
      pollCnt <= '0;
    else
      pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || dpStrb.lossClr)
      lossCnt <= '0;
    else if (lossCnt != LOSS_LAST)
      lossCnt <= lossCnt + 1'b1;
  end

  assign dpStat.pollAtZero = (pollCnt == '0);
  assign dpStat.lossAtLast = (lossCnt == LOSS_LAST);

  assign clrHit = regWrEn && (regAddr == 1'b0) && regWrData[CHG_BIT];
  assign enWr   = regWrEn && (regAddr == 1'b1);
  assign unusedWrBits = ^{regWrData[REG_W-1:CHG_BIT+1], regWrData[CHG_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      chgFlag <= 1'b0;
      chgEn   <= 1'b0;
    end else begin
      if (dpStrb.setChg)   chgFlag <= 1'b1;
      else if (clrHit)     chgFlag <= 1'b0;
      if (enWr)            chgEn   <= regWrData[CHG_BIT];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == 1'b0) regRdData[CHG_BIT] = chgFlag;
    else                 regRdData[CHG_BIT] = chgEn;
  end

  assign irq = chgFlag & chgEn;

  // R5: loss counter saturates at its last value
  p_loss_bound_r5: assert property (@(posedge clk) disable iff (rst)
    lossCnt <= LOSS_LAST);

  // R6: activity or leaving ready restarts the loss timer
  p_loss_restart_r6: assert property (@(posedge clk) disable iff (rst)
    dpStrb.lossClr |=> (lossCnt == '0));

  // R7: a state change always leaves the flag set
  p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    dpStrb.setChg |=> chgFlag);

  // R8: without a clear the flag holds
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (chgFlag && !clrHit) |=> chgFlag);

endmodule

// File: rtl/hotplug_ctrl.sv
module hotplug_ctrl
  import hotplug_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 64'd125_000_000,
  parameter longint unsigned POLL_NS = 64'd100_000_000,
  parameter longint unsigned LOSS_NS = 64'd200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sigValid,
  input  logic             rxInit,
  input  logic             phyRdy,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic             comResetReq,
  output logic             linkReady,
  output logic             irq,
  output logic [REG_W-1:0] regRdData
);

  localparam longint unsigned POLL_CYC = nsToCycles(CLK_HZ, POLL_NS);
  localparam longint unsigned LOSS_CYC = nsToCycles(CLK_HZ, LOSS_NS);

  dp_strobe_t dpStrb;
  dp_status_t dpStat;

  hotplug_ctrl_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sigValid    (sigValid),
    .rxInit      (rxInit),
    .phyRdy      (phyRdy),
    .dpStat      (dpStat),
    .dpStrb      (dpStrb),
    .comResetReq (comResetReq),
    .linkReady   (linkReady)
  );

  hotplug_ctrl_dp #(
    .POLL_CYC (POLL_CYC),
    .LOSS_CYC (LOSS_CYC)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .dpStrb    (dpStrb),
    .dpStat    (dpStat),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irq       (irq)
  );

endmodule

// File: tb/hotplug_ctrl_bench.sv
module hotplug_ctrl_bench;

  localparam int P = 100;  // 800 ns at 125 MHz
  localparam int L = 25;   // 200 ns at 125 MHz

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sigValid = 1'b0, rxInit = 1'b0, phyRdy = 1'b0;
  logic regWrEn = 1'b0, regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic comResetReq, linkReady, irq;
  logic [31:0] regRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hotplug_ctrl #(
    .CLK_HZ  (64'd125_000_000),
    .POLL_NS (64'd800),
    .LOSS_NS (64'd200)
  ) u_hotplug_ctrl (
    .clk(clk), .rst(rst), .sigValid(sigValid), .rxInit(rxInit), .phyRdy(phyRdy),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .comResetReq(comResetReq), .linkReady(linkReady), .irq(irq), .regRdData(regRdData)
  );

  typedef struct packed {
    logic [15:0] n;
    logic sv, ri, pr;
    logic expRdy, expReq;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{16'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 pulse ends
    '{16'd98, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 quiet inside period
    '{16'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 next pulse at 100
    '{16'd1,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 init seen, phy not ready
    '{16'd99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 pulse suppressed
    '{16'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 enter ready
    '{16'd40, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 activity holds ready
    '{16'd24, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 one short of timeout
    '{16'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 restart
    '{16'd24, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 full window again
    '{16'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1}   // R5 fall back, pulse
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic addr, logic [31:0] data);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(logic addr, output logic [31:0] data);
    regAddr = addr;
    #1;
    data = regRdData;
  endtask

  task automatic drive(logic sv, logic ri, logic pr);
    sigValid = sv; rxInit = ri; phyRdy = pr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int pulses;
    repeat (3) tick();
    rst = 1'b0;

    // R1 reset state
    check("R1 req", {31'b0, comResetReq}, 32'd1);
    check("R1 ready", {31'b0, linkReady}, 32'd0);
    check("R1 irq", {31'b0, irq}, 32'd0);
    regRead(1'b0, rd); check("R1 status", rd, 32'd0);
    regRead(1'b1, rd); check("R1 enable", rd, 32'd0);

    // table walk
    foreach (VEC[i]) begin
      drive(VEC[i].sv, VEC[i].ri, VEC[i].pr);
      repeat (int'(VEC[i].n)) tick();
      check($sformatf("R3/R4/R5/R6 vec%0d ready", i), {31'b0, linkReady}, {31'b0, VEC[i].expRdy});
      check($sformatf("R2/R3/R4/R5 vec%0d req", i), {31'b0, comResetReq}, {31'b0, VEC[i].expReq});
    end
    drive(1'b0, 1'b0, 1'b0);

    // R7 flag set by the changes above, R9 masked
    regRead(1'b0, rd); check("R7 flag", rd, 32'h0001_0000);
    check("R9 masked irq", {31'b0, irq}, 32'd0);

    // R8 write without bit 16 leaves flag
    regWrite(1'b0, 32'hFFFE_FFFF);
    regRead(1'b0, rd); check("R8 no clear", rd, 32'h0001_0000);
    regWrite(1'b0, 32'h0001_0000);
    regRead(1'b0, rd); check("R8 clear", rd, 32'd0);

    // R9 enable
    regWrite(1'b1, 32'h0001_0000);
    regRead(1'b1, rd); check("R9 enable rd", rd, 32'h0001_0000);
    check("R9 irq idle", {31'b0, irq}, 32'd0);

    // R4 init and phy ready in one cycle, R7/R9 irq at same edge
    drive(1'b1, 1'b1, 1'b1);
    tick();
    drive(1'b1, 1'b0, 1'b1);
    check("R4 same-cycle ready", {31'b0, linkReady}, 32'd1);
    check("R9 irq on change", {31'b0, irq}, 32'd1);

    // R8 set wins over clear
    regWrite(1'b0, 32'h0001_0000);
    check("R8 cleared irq", {31'b0, irq}, 32'd0);
    drive(1'b0, 1'b0, 1'b1);
    repeat (L - 1) tick();
    check("R5 still ready", {31'b0, linkReady}, 32'd1);
    regWrite(1'b0, 32'h0001_0000);
    check("R5 dropped", {31'b0, linkReady}, 32'd0);
    regRead(1'b0, rd); check("R8 set wins", rd, 32'h0001_0000);
    check("R9 irq after loss", {31'b0, irq}, 32'd1);

    // R10 reset from ready
    drive(1'b1, 1'b1, 1'b1);
    tick();
    check("R10 ready before reset", {31'b0, linkReady}, 32'd1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0);
    check("R10 ready", {31'b0, linkReady}, 32'd0);
    check("R10 req", {31'b0, comResetReq}, 32'd1);
    check("R10 irq", {31'b0, irq}, 32'd0);
    regRead(1'b0, rd); check("R10 status", rd, 32'd0);
    regRead(1'b1, rd); check("R10 enable", rd, 32'd0);

    // R3 pulse count over three periods
    pulses = 0;
    if (comResetReq) pulses++;
    for (int k = 0; k < 3 * P; k++) begin
      tick();
      if (comResetReq) pulses++;
    end
    check("R3 pulse count", pulses, 32'd4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule